// File: doc/BRIEF.md
# Per-Processor Device Interrupt Masking Unit

The unit gathers up to 64 device interrupt request lines into one shared raw request vector and gives each of up to four processors its own 64-bit mask. Each processor's effective interrupt vector is its mask ANDed with the raw vector. The unit recomputes this vector every time software writes a mask and every time a device raises or drops a line. For every processor it drives one level interrupt output. It also drives one-cycle per-source pulses that mark which effective bits have just become active and which have just been withdrawn.

Devices signal requests with synchronous set and clear strobes that carry a source index. Software reaches the masks, the effective vectors and the raw vector over a simple 64-bit register bus. Register slots sit on 64-byte strides above a base address. Only full 64-bit accesses are accepted. Any illegal access leaves every register as it was and raises a sticky error flag, which only reset clears.

Top module: `dev_irq_mask_unit`

## Requirements
- R1: After a synchronous active-high reset the following are zero: every mask, every effective vector, the raw vector, all interrupt outputs, all pulse outputs, the read data and the error flag.
- R2: For every processor p, the effective vector always equals mask p AND the raw vector. Reading slot 4+p returns it. irq_dev[p] is the OR of the bits of that vector, registered at the same clock edge.
- R3: A mask write that makes bit n of a processor's effective vector become set raises irq_rise[p*64+n] for exactly the one cycle after the write edge.
- R4: A mask write that clears bit n where that bit was active in the effective vector raises irq_fall[p*64+n] for one cycle, and irq_dev[p] follows the new vector.
- R5: A set strobe with index n sets raw bit n. Each processor whose mask has bit n set gets a rise pulse on bit n, unless that bit was already active.
- R6: A clear strobe with index n clears raw bit n and gives a fall pulse to each processor that had bit n active. A clear strobe for a raw bit that is already zero changes no state and gives no pulse.
- R7: The register slot is (bus_addr - BASE_ADDR) >> 6. Slot p (p < NCPU) is mask p and is readable and writable. Slot 4+p is effective vector p and is read-only. Slot 8 is the raw vector and is read-only. Read data appears with rd_valid in the cycle after the request.
- R8: The following are illegal: bus_size other than 3 (the 8-byte code), a write to slot 4..8, a slot that has no register, and an address below BASE_ADDR. An illegal access changes no register, returns zero read data and sets err, which stays set until reset.
- R9: When a set strobe and a clear strobe name the same index in one cycle, the set wins. A mask write and a device strobe in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code, 3 = 64-bit |
| bus_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| dev_set | input | 1 | Raise a device request line |
| dev_clr | input | 1 | Drop a device request line |
| dev_idx | input | log2(SRC_W) | Source index for set or clear |
| irq_dev | output | NCPU | Per-processor device interrupt level |
| irq_rise | output | NCPU*SRC_W | Per-source newly-active pulses |
| irq_fall | output | NCPU*SRC_W | Per-source withdrawn pulses |
| err | output | 1 | Sticky illegal-access flag |

## Verification
The assertions assume that dev_idx is always a known value below SRC_W, and that the bus inputs are stable and free of X around every edge. The pulse checks further assume that no mask write and no device strobe arrive in back-to-back cycles, so each pulse can be traced to one cause. The stimulus drives every input on the falling edge and holds it for one full cycle. It inserts an idle cycle between operations and uses only in-range source indices, so both assumptions always hold.

// File: rtl/dim_pkg.sv
package dim_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  localparam int unsigned SLOT_SHIFT = 6;
  localparam int unsigned SLOT_EFF   = 4;
  localparam int unsigned SLOT_RAW   = 8;

  typedef struct packed {
    logic       hit_mask;
    logic       hit_eff;
    logic       hit_raw;
    logic [1:0] cpu;
    logic       illegal;
  } dec_t;
endpackage

// File: rtl/dim_decode.sv
module dim_decode
  import dim_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0010_0000,
  parameter int unsigned NCPU      = 4
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] slot;
  logic [ADDR_W-1:0] eslot;
  logic              below;
  logic              any_hit;

  always_comb begin
    below        = addr < BASE;
    rel          = addr - BASE;
    slot         = rel >> SLOT_SHIFT;
    eslot        = slot - ADDR_W'(SLOT_EFF);
    dec.hit_mask = !below && (slot < ADDR_W'(NCPU));
    dec.hit_eff  = !below && (slot >= ADDR_W'(SLOT_EFF)) &&
                   (slot < ADDR_W'(SLOT_EFF + NCPU));
    dec.hit_raw  = !below && (slot == ADDR_W'(SLOT_RAW));
    dec.cpu      = dec.hit_eff ? eslot[1:0] : slot[1:0];
    any_hit      = dec.hit_mask | dec.hit_eff | dec.hit_raw;
    dec.illegal  = valid && ((size != SZ_DBL) || !any_hit ||
                   (write && (dec.hit_eff || dec.hit_raw)));
  end
endmodule

// File: rtl/dim_raw_vec.sv
module dim_raw_vec #(
  parameter int unsigned SRC_W = 64,
  localparam int unsigned IDX_W = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [SRC_W-1:0] raw_q,
  output logic [SRC_W-1:0] raw_next
);
  logic [SRC_W-1:0] onehot;

  always_comb begin
    onehot   = '0;
    onehot[idx_i] = 1'b1;
    raw_next = raw_q;
    if (clr_i) raw_next = raw_next & ~onehot;
    if (set_i) raw_next = raw_next | onehot;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_next;
  end
endmodule

// File: rtl/dim_cpu_slice.sv
module dim_cpu_slice #(
  parameter int unsigned SRC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [63:0]      wdata,
  input  logic [SRC_W-1:0] raw_next,
  output logic [SRC_W-1:0] mask_q,
  output logic [SRC_W-1:0] eff_q,
  output logic [SRC_W-1:0] rise_q,
  output logic [SRC_W-1:0] fall_q,
  output logic             irq_q
);
  logic [SRC_W-1:0] mask_next;
  logic [SRC_W-1:0] eff_next;

  always_comb begin
    mask_next = wr_en ? wdata[SRC_W-1:0] : mask_q;
    eff_next  = mask_next & raw_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      eff_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_next;
      eff_q  <= eff_next;
      rise_q <= eff_next & ~eff_q;
      fall_q <= eff_q & ~eff_next;
      irq_q  <= |eff_next;
    end
  end
endmodule

// File: rtl/dev_irq_mask_unit.sv
module dev_irq_mask_unit
  import dim_pkg::*;
#(
  parameter int unsigned NCPU      = 4,
  parameter int unsigned SRC_W     = 64,
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0010_0000,
  localparam int unsigned IDX_W    = $clog2(SRC_W)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [1:0]             bus_size,
  input  logic [63:0]            bus_wdata,
  output logic                   rd_valid,
  output logic [63:0]            rd_data,
  input  logic                   dev_set,
  input  logic                   dev_clr,
  input  logic [IDX_W-1:0]       dev_idx,
  output logic [NCPU-1:0]        irq_dev,
  output logic [NCPU*SRC_W-1:0]  irq_rise,
  output logic [NCPU*SRC_W-1:0]  irq_fall,
  output logic                   err
);
  dec_t             dec;
  logic [SRC_W-1:0] raw_q;
  logic [SRC_W-1:0] raw_next;
  logic [SRC_W-1:0] mask_arr [NCPU];
  logic [SRC_W-1:0] eff_arr  [NCPU];
  logic [NCPU*SRC_W-1:0] mask_flat;
  logic [NCPU*SRC_W-1:0] eff_flat;
  logic             legal;

  dim_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NCPU(NCPU)) i_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .size(bus_size), .dec(dec)
  );

  dim_raw_vec #(.SRC_W(SRC_W)) i_raw (
    .clk(clk), .rst(rst), .set_i(dev_set), .clr_i(dev_clr),
    .idx_i(dev_idx), .raw_q(raw_q), .raw_next(raw_next)
  );

  assign legal = bus_valid && !dec.illegal;

  for (genvar p = 0; p < NCPU; p++) begin : g_cpu
    logic wr_this;
    assign wr_this = legal && bus_write && dec.hit_mask && (dec.cpu == 2'(p));
    dim_cpu_slice #(.SRC_W(SRC_W)) i_slice (
      .clk(clk), .rst(rst), .wr_en(wr_this), .wdata(bus_wdata),
      .raw_next(raw_next), .mask_q(mask_arr[p]), .eff_q(eff_arr[p]),
      .rise_q(irq_rise[p*SRC_W +: SRC_W]),
      .fall_q(irq_fall[p*SRC_W +: SRC_W]),
      .irq_q(irq_dev[p])
    );
    assign mask_flat[p*SRC_W +: SRC_W] = mask_arr[p];
    assign eff_flat[p*SRC_W +: SRC_W]  = eff_arr[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
    end else begin
      rd_valid <= bus_valid && !bus_write;
      rd_data  <= '0;
      if (bus_valid && dec.illegal) err <= 1'b1;
      if (legal && !bus_write) begin
        if (dec.hit_mask)     rd_data <= 64'(mask_arr[dec.cpu]);
        else if (dec.hit_eff) rd_data <= 64'(eff_arr[dec.cpu]);
        else if (dec.hit_raw) rd_data <= 64'(raw_q);
      end
    end
  end
endmodule

// File: rtl/dim_checker.sv
module dim_checker #(
  parameter int unsigned NCPU  = 4,
  parameter int unsigned SRC_W = 64,
  localparam int unsigned IDX_W = $clog2(SRC_W)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [1:0]            bus_size,
  input logic                  dev_set,
  input logic                  dev_clr,
  input logic [IDX_W-1:0]      dev_idx,
  input logic [SRC_W-1:0]      raw_q,
  input logic [NCPU*SRC_W-1:0] mask_flat,
  input logic [NCPU*SRC_W-1:0] eff_flat,
  input logic [NCPU*SRC_W-1:0] irq_rise,
  input logic [NCPU*SRC_W-1:0] irq_fall,
  input logic [NCPU-1:0]       irq_dev,
  input logic                  rd_valid,
  input logic                  err
);
  for (genvar p = 0; p < NCPU; p++) begin : g_p
    // R2: effective vector follows mask and raw vector held in other modules
    a_r2_eff_tracks: assert property (@(posedge clk) disable iff (rst)
      eff_flat[p*SRC_W +: SRC_W] == (mask_flat[p*SRC_W +: SRC_W] & raw_q));
    a_r2_level_or: assert property (@(posedge clk) disable iff (rst)
      irq_dev[p] == (|eff_flat[p*SRC_W +: SRC_W]));
  end

  a_r3_edge_disjoint: assert property (@(posedge clk) disable iff (rst)
    (irq_rise & irq_fall) == '0);

  a_r5_set_lands: assert property (@(posedge clk) disable iff (rst)
    dev_set |=> raw_q[$past(dev_idx)]);

  a_r6_spurious_drop: assert property (@(posedge clk) disable iff (rst)
    (dev_clr && !dev_set && !raw_q[dev_idx]) |=> $stable(raw_q));

  a_r7_read_valid: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rd_valid);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r8_bad_size_no_write: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_size != 2'd3) |=> ($stable(mask_flat) && err));
endmodule

bind dev_irq_mask_unit dim_checker #(.NCPU(NCPU), .SRC_W(SRC_W)) i_dim_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_size(bus_size), .dev_set(dev_set), .dev_clr(dev_clr),
  .dev_idx(dev_idx), .raw_q(raw_q), .mask_flat(mask_flat),
  .eff_flat(eff_flat), .irq_rise(irq_rise), .irq_fall(irq_fall),
  .irq_dev(irq_dev), .rd_valid(rd_valid), .err(err)
);

// File: tb/test_dev_irq_mask_unit.sv
module test_dev_irq_mask_unit;
  localparam int NCPU = 4;
  localparam int SRC_W = 64;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 0, bus_write = 0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'd3;
  logic [63:0] bus_wdata = '0;
  logic rd_valid;
  logic [63:0] rd_data;
  logic dev_set = 0, dev_clr = 0;
  logic [5:0] dev_idx = '0;
  logic [NCPU-1:0] irq_dev;
  logic [NCPU*SRC_W-1:0] irq_rise, irq_fall;
  logic err;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_mask [NCPU];
  logic [63:0] m_prev [NCPU];
  logic [63:0] m_raw;

  always #4 clk = ~clk;

  dev_irq_mask_unit i_dev_irq_mask_unit (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dev_set(dev_set),
    .dev_clr(dev_clr), .dev_idx(dev_idx), .irq_dev(irq_dev),
    .irq_rise(irq_rise), .irq_fall(irq_fall), .err(err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] eff(input int p);
    return m_mask[p] & m_raw;
  endfunction

  task automatic snap();
    for (int p = 0; p < NCPU; p++) m_prev[p] = eff(p);
  endtask

  task automatic chk_edges(input string req);
    logic [NCPU-1:0] lvl;
    for (int p = 0; p < NCPU; p++) begin
      chk({req, " rise"}, irq_rise[p*SRC_W +: SRC_W], eff(p) & ~m_prev[p]);
      chk({req, " fall"}, irq_fall[p*SRC_W +: SRC_W], m_prev[p] & ~eff(p));
      lvl[p] = |eff(p);
    end
    chk({req, " irq_dev"}, 64'(irq_dev), 64'(lvl));
  endtask

  task automatic wr(input int slot, input logic [63:0] d, input logic [1:0] sz = 2'd3);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = BASE + 32'(slot * 64);
    bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_size = 2'd3;
  endtask

  task automatic rd(input logic [31:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = rd_valid ? rd_data : 64'hDEAD;
  endtask

  task automatic dev(input logic s, input logic c, input int idx);
    @(negedge clk);
    dev_set = s; dev_clr = c; dev_idx = 6'(idx);
    @(negedge clk);
    dev_set = 0; dev_clr = 0;
  endtask

  task automatic mask_wr(input int p, input logic [63:0] d, input string req);
    snap(); m_mask[p] = d;
    wr(p, d);
    chk_edges(req);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int p = 0; p < NCPU; p++) m_mask[p] = '0;
    m_raw = '0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 irq_dev", 64'(irq_dev), 0);
    chk("R1 rise", 64'(|irq_rise), 0);
    chk("R1 err", 64'(err), 0);
    rd(BASE, d);               chk("R1 mask0", d, 0);
    rd(BASE + 8 * 64, d);      chk("R1 raw", d, 0);
  endtask

  task automatic t_mask_rw();
    logic [63:0] d;
    mask_wr(1, 64'hF0F0_0000_0000_00F0, "R3 no raw");
    rd(BASE + 64, d); chk("R7 mask1 readback", d, m_mask[1]);
  endtask

  task automatic t_raise();
    logic [63:0] d;
    mask_wr(0, 64'h20, "R3 mask0");
    mask_wr(2, 64'h8000_0000_0000_0020, "R3 mask2");
    snap(); m_raw[5] = 1; dev(1, 0, 5); chk_edges("R5 raise 5");
    rd(BASE + 8 * 64, d); chk("R5 raw read", d, m_raw);
    snap(); dev(1, 0, 5); chk_edges("R5 re-raise 5");
  endtask

  task automatic t_mask_edges();
    mask_wr(0, 64'h0, "R4 mask clear");
    mask_wr(0, 64'h20, "R3 mask set active");
  endtask

  task automatic t_drop();
    snap(); dev(0, 1, 9); chk_edges("R6 spurious drop");
    chk("R6 raw unchanged", m_raw, 64'h20);
    snap(); m_raw[5] = 0; dev(0, 1, 5); chk_edges("R6 drop 5");
  endtask

  task automatic t_eff_read();
    logic [63:0] d;
    mask_wr(3, 64'h8000_0000_0000_0001, "R3 mask3");
    snap(); m_raw[63] = 1; dev(1, 0, 63); chk_edges("R5 raise 63");
    rd(BASE + 7 * 64, d); chk("R2 eff3", d, eff(3));
    rd(BASE + 6 * 64, d); chk("R2 eff2", d, eff(2));
  endtask

  task automatic t_same_cycle();
    logic [63:0] d;
    snap(); m_raw[7] = 1; dev(1, 1, 7); chk_edges("R9 set wins");
    rd(BASE + 8 * 64, d); chk("R9 raw", d, m_raw);
    snap();
    m_mask[1] = 64'h1; m_raw[0] = 1;
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = BASE + 64; bus_wdata = 64'h1;
    dev_set = 1; dev_idx = 6'd0;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; dev_set = 0;
    chk_edges("R9 write plus raise");
  endtask

  task automatic t_illegal();
    logic [63:0] d;
    wr(5, 64'hFFFF);
    chk("R8 eff write err", 64'(err), 1);
    rd(BASE + 5 * 64, d); chk("R8 eff unchanged", d, eff(1));
    wr(1, 64'hFFFF_FFFF, 2'd2);
    rd(BASE + 64, d); chk("R8 size mask unchanged", d, m_mask[1]);
    wr(8, '1);
    rd(BASE + 8 * 64, d); chk("R8 raw unchanged", d, m_raw);
    rd(BASE + 12 * 64, d); chk("R8 unmapped read zero", d, 0);
    rd(BASE - 64, d); chk("R8 below base zero", d, 0);
    chk("R8 err still set", 64'(err), 1);
    do_reset();
    chk("R1 err cleared", 64'(err), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_mask_rw();
    t_raise();
    t_mask_edges();
    t_drop();
    t_eff_read();
    t_same_cycle();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule